// File: doc/BRIEF.md
# Partitioned SIMD Adder/Subtractor

A combinational 16-bit adder/subtractor that can be split at runtime into narrower independent lanes. Lane boundaries can sit between nibbles, and a boundary-enable vector chooses which ones are active. The same datapath can therefore work as one 16-bit unit, two 8-bit units, four 4-bit units, or any other contiguous grouping of nibbles. No carry crosses an active boundary.

Each lane adds, subtracts or negates its own slice of the operands. A lane takes its carry-in from the carry-in bit at the lane's lowest nibble index. It reports its carry-out at that same index. Because the block has no registers, the results follow the inputs directly.

Top module: `simd_addsub`

## Requirements
- R1: Bit i of `split_i` enables the boundary between nibble i and nibble i+1, that is between bits 4i+3 and 4i+4. `3'b000` gives one 16-bit lane, `3'b010` gives two 8-bit lanes (bits 7:0 and 15:8), and `3'b111` gives four 4-bit lanes.
- R2: With `op_i = 2'b00` (add), each lane's result is (a + b + carry-in) modulo 2^w, where w is the lane width and a, b are the lane's slices of the operands.
- R3: With `op_i = 2'b01` (subtract), each lane's result is (a + ~b + carry-in) modulo 2^w.
- R4: With `op_i = 2'b10` (negate), each lane's result is the two's complement of its slice of a, computed as ~a + 1. In this mode `b_i` and `cin_i` have no effect.
- R5: The code `op_i = 2'b11` behaves exactly like add.
- R6: A lane's carry-in is `cin_i[j]`, where j is the lane's lowest nibble index. Carry-in bits at any other nibble of the lane are ignored.
- R7: `cout_o[j]` is set when lane j's unmasked sum reaches 2^w, where j is the lane's lowest nibble index. Every `cout_o` bit that is not the lowest nibble of a lane is 0.
- R8: A lane's result and carry-out depend only on the operand bits inside that lane. No carry crosses an active boundary.
- R9: The outputs are a purely combinational function of the inputs. They settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand a |
| b_i | input | 16 | Operand b |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 add |
| cin_i | input | 4 | Carry-in, one bit per nibble position |
| split_i | input | 3 | Boundary enables between adjacent nibbles |
| y_o | output | 16 | Lane-wise result |
| cout_o | output | 4 | Carry-out, reported at each lane's lowest nibble |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles and four of them. It sweeps all eight boundary patterns, including the uneven lanes of 4+12 and 12+4 bits, together with all four operation codes and four carry-in patterns. Edge operands such as 0x0000, 0xFFFF, 0x8000 and equal pairs are mixed with pseudo-random ones. This exercises carry chains that run across disabled boundaries and carry-in bits placed inside lanes, so the cut and the ignore rules are tested in every lane shape.

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int LANE_W = 4,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a_i,
  input  logic [LANE_W*LANES-1:0] b_i,
  input  logic [1:0]              op_i,
  input  logic [LANES-1:0]        cin_i,
  input  logic [LANES-2:0]        split_i,
  output logic [LANE_W*LANES-1:0] y_o,
  output logic [LANES-1:0]        cout_o
);
  localparam int W = LANE_W * LANES;

  logic neg, sub;
  assign neg = (op_i == 2'b10);
  assign sub = (op_i == 2'b01);

  logic [LANES-1:0] head, tail, nib_ci, nib_co, lane_co;

  for (genvar k = 0; k < LANES; k++) begin : g_nib
    logic [LANE_W-1:0] opa, opb;
    logic [LANE_W:0]   sum;

    if (k == 0) begin : g_first
      assign head[k] = 1'b1;
    end else begin : g_rest
      assign head[k] = split_i[k-1];
    end

    if (k == LANES-1) begin : g_top
      assign tail[k] = 1'b1;
    end else begin : g_mid
      assign tail[k] = split_i[k];
    end

    if (k == 0) begin : g_ci0
      assign nib_ci[k] = neg ? 1'b1 : cin_i[k];
    end else begin : g_cin
      assign nib_ci[k] = head[k] ? (neg ? 1'b1 : cin_i[k]) : nib_co[k-1];
    end

    assign opa = neg ? ~a_i[k*LANE_W +: LANE_W] : a_i[k*LANE_W +: LANE_W];
    assign opb = neg ? '0 : (sub ? ~b_i[k*LANE_W +: LANE_W] : b_i[k*LANE_W +: LANE_W]);
    assign sum = {1'b0, opa} + {1'b0, opb} + {{LANE_W{1'b0}}, nib_ci[k]};

    assign y_o[k*LANE_W +: LANE_W] = sum[LANE_W-1:0];
    assign nib_co[k] = sum[LANE_W];

    if (k == LANES-1) begin : g_lc_top
      assign lane_co[k] = nib_co[k];
    end else begin : g_lc_mid
      assign lane_co[k] = tail[k] ? nib_co[k] : lane_co[k+1];
    end

    assign cout_o[k] = head[k] & lane_co[k];
  end

  logic unused_w;
  assign unused_w = ^{W[0]};
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int LANE_W = 4,
  parameter int LANES  = 4
) (
  input logic [LANE_W*LANES-1:0] a_i,
  input logic [LANE_W*LANES-1:0] b_i,
  input logic [1:0]              op_i,
  input logic [LANES-1:0]        cin_i,
  input logic [LANES-2:0]        split_i,
  input logic [LANE_W*LANES-1:0] y_o,
  input logic [LANES-1:0]        cout_o
);
  logic [LANES-1:0] starts;
  logic [LANE_W:0]  low_sum;

  assign starts = {split_i, 1'b1};

  always_comb begin
    low_sum = {1'b0, a_i[LANE_W-1:0]} + {1'b0, b_i[LANE_W-1:0]} + {{LANE_W{1'b0}}, cin_i[0]};

    for (int k = 1; k < LANES; k++) begin
      if (!split_i[k-1])
        a_r7_cout_at_start: assert (!cout_o[k]);
    end

    if (op_i == 2'b10 && a_i == '0)
      a_r4_neg_of_zero: assert (y_o == '0 && cout_o == starts);

    if (op_i == 2'b01 && a_i == b_i && cin_i == '1)
      a_r3_sub_self: assert (y_o == '0 && cout_o == starts);

    if (op_i == 2'b00 && b_i == '0 && cin_i == '0)
      a_r2_add_zero: assert (y_o == a_i && cout_o == '0);

    if (split_i[0] && op_i[1] == op_i[0])
      if (op_i == 2'b00 || op_i == 2'b11)
        a_r8_low_lane_isolated: assert (y_o[LANE_W-1:0] == low_sum[LANE_W-1:0] && cout_o[0] == low_sum[LANE_W]);
  end
endmodule

bind simd_addsub simd_addsub_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/simd_addsub_test.sv
module simd_addsub_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a, b, y;
  logic [1:0]  op;
  logic [3:0]  cin, cout;
  logic [2:0]  sp;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  simd_addsub uut (.a_i(a), .b_i(b), .op_i(op), .cin_i(cin), .split_i(sp), .y_o(y), .cout_o(cout));

  task automatic model(input logic [15:0] ma, mb, input logic [1:0] mop,
                       input logic [3:0] mci, input logic [2:0] msp,
                       output logic [15:0] ey, output logic [3:0] ec);
    int s;
    longint m, av, bv, ci, sum;
    int lo, w;
    s = 0; ey = '0; ec = '0;
    for (int k = 0; k < 4; k++) begin
      if (k == 3 || msp[k]) begin
        lo = s * 4; w = (k - s + 1) * 4;
        m = (64'd1 << w) - 1;
        av = (longint'(ma) >> lo) & m;
        bv = (longint'(mb) >> lo) & m;
        ci = mci[s];
        if (mop == 2'b10) begin av = (~av) & m; bv = 0; ci = 1; end
        else if (mop == 2'b01) bv = (~bv) & m;
        sum = av + bv + ci;
        ey = ey | 16'((sum & m) << lo);
        ec[s] = ((sum >> w) & 1) != 0;
        s = k + 1;
      end
    end
  endtask

  task automatic check(input string tag, input logic [15:0] ey, input logic [3:0] ec);
    tests++;
    if (y !== ey) begin
      fails++;
      $display("FAIL %s result: a=%h b=%h op=%b cin=%b sp=%b got %h exp %h", tag, a, b, op, cin, sp, y, ey);
    end
    tests++;
    if (cout !== ec) begin
      fails++;
      $display("FAIL R7 carry (%s): a=%h b=%h op=%b cin=%b sp=%b got %b exp %b", tag, a, b, op, cin, sp, cout, ec);
    end
  endtask

  task automatic apply(input logic [15:0] ta, tb, input logic [1:0] top,
                       input logic [3:0] tci, input logic [2:0] tsp, input string tag);
    logic [15:0] ey; logic [3:0] ec;
    @(posedge clk);
    a = ta; b = tb; op = top; cin = tci; sp = tsp;
    @(negedge clk);
    model(ta, tb, top, tci, tsp, ey, ec);
    check(tag, ey, ec);
  endtask

  function automatic logic [15:0] pick(input int v, inout logic [31:0] st);
    case (v)
      0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'h8000; 3: return 16'h1234;
      4: return 16'hABCD; 5: return 16'h0001; 6: return 16'h7FFF; 7: return 16'hF0F0;
      default: begin st = st * 32'd1664525 + 32'd1013904223; return st[31:16]; end
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] st;
    logic [15:0] va, vb;
    logic [3:0] cins [4];
    string tag;
    st = 32'h1ACE_5EED;
    cins[0] = 4'b0000; cins[1] = 4'b1111; cins[2] = 4'b0101; cins[3] = 4'b1010;
    a = '0; b = '0; op = '0; cin = '0; sp = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle-zero", 16'h0000, 4'b0000);

    apply(16'h00FF, 16'h0001, 2'b00, 4'b0000, 3'b010, "R1 two lanes");
    check("R8 cut at middle", 16'h0000, 4'b0001);
    apply(16'h00FF, 16'h0001, 2'b00, 4'b0000, 3'b000, "R1 one lane");
    check("R8 carry through", 16'h0100, 4'b0000);
    apply(16'hFFFF, 16'h1111, 2'b00, 4'b0000, 3'b111, "R1 four lanes");
    check("R7 all starts", 16'h0000, 4'b1111);
    apply(16'h0000, 16'h0000, 2'b00, 4'b1110, 3'b000, "R6 inner cin ignored");
    check("R6 inner cin", 16'h0000, 4'b0000);
    apply(16'h0000, 16'h0000, 2'b00, 4'b0100, 3'b010, "R6 head cin used");
    check("R6 head cin", 16'h0100, 4'b0000);
    apply(16'h1234, 16'hBEEF, 2'b10, 4'b1111, 3'b111, "R4 neg ignores b/cin");
    check("R4 neg", 16'hFEDC, 4'b0000);
    apply(16'h0500, 16'h0000, 2'b01, 4'b0000, 3'b000, "R3 sub no cin");
    check("R3 sub", 16'h04FF, 4'b0001);

    @(posedge clk);
    a = 16'h0003; b = 16'h0004; op = 2'b00; cin = 4'b0000; sp = 3'b111;
    #1;
    check("R9 no clock edge", 16'h0007, 4'b0000);
    a = 16'h0002;
    #1;
    check("R9 follows input", 16'h0006, 4'b0000);

    for (int v = 0; v < 64; v++) begin
      va = pick(v % 8 + (v >= 16 ? 8 : 0), st);
      vb = pick((v / 8) % 8 + (v >= 16 ? 8 : 0), st);
      if (v == 9) vb = va;
      for (int m = 0; m < 8; m++)
        for (int o = 0; o < 4; o++)
          for (int c = 0; c < 4; c++) begin
            case (o)
              0: tag = "R2 add";
              1: tag = "R3 sub";
              2: tag = "R4 neg";
              default: tag = "R5 op11";
            endcase
            if (c >= 1 && o != 2) tag = {tag, " R6 cin"};
            apply(va, vb, 2'(o), cins[c], 3'(m), {tag, " R1 R8"});
          end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end
endmodule